// File: doc/BRIEF.md
# Pulse charge and time extractor

This block watches a stream of digitized photomultiplier samples, one per 10 ns sampling tick, and turns each pulse into one record. A differenced copy of the stream, the current sample minus the sample k steps earlier, marks where a pulse begins and ends. While the difference stays above a programmable level, the block sums the raw samples. It then removes a baseline taken from the eight samples just before the pulse, scaled to the pulse length.

The block also finds the highest sample of the pulse and looks at its neighbours on both sides. From the two height drops, a table gives a position inside the sample period in tenths, so each record carries a coarse sample index and a fine step from 0 to 9. A pulse that runs too long is cut off and marked. A new pulse may only open after the difference has dropped at least once.

Top module: `qt_pulse_extract`

## Requirements
- R1: While rst_n is low and after its release, before any pulse, pulse_valid, pulse_charge, pulse_coarse, pulse_fine and pulse_ovf are all zero.
- R2: For each accepted sample x[n] the difference is d = x[n] - x[n-k], with k taken from dos_k: 0 means 1, values 1 to 4 are used as is, 5 to 7 mean 4. Samples before reset count as 0.
- R3: A hit opens on a sample whose d is greater than dos_thr (both two's complement), includes every following sample with d > dos_thr, and closes on the first sample with d <= dos_thr. That sample is not part of the hit. Each closed hit gives exactly one record.
- R4: pulse_charge = floor((8*S - L*P)/8), where S is the sum of the samples in the hit, L is the number of samples in the hit, and P is the sum of the 8 accepted samples just before the first hit sample.
- R5: pulse_coarse is the index of the first largest sample of the hit. Accepted samples are counted from 0 after reset, modulo 65536.
- R6: The left sample is the one before the peak, and the right sample is the one after it (the closing sample if the peak is last). a = max(peak-left,0) and b = max(peak-right,0) are shifted right by the smallest s that brings both below 8, giving qa and qb. pulse_fine = min(9, floor((20*qa + qa + qb)/(2*(qa+qb)))), or 5 when qa+qb = 0.
- R7: A hit holds at most 32 samples. If a 33rd sample has d > dos_thr, the hit closes on it without including it and pulse_ovf = 1. Otherwise pulse_ovf = 0.
- R8: A hit opens only if the previous accepted sample had d <= dos_thr, so after an overflow close no hit opens until a sample with d <= dos_thr has passed.
- R9: A cycle with in_valid low accepts no sample. The sample index, history and hit state stay unchanged.
- R10: pulse_valid is high for exactly one cycle, on the second rising edge after the closing sample is accepted. The result fields keep their values until the next record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_sample holds a new sample this cycle |
| in_sample | input | 10 | Unsigned waveform sample |
| dos_k | input | 3 | Difference distance k (clamped to 1..4) |
| dos_thr | input | 11 | Signed hit threshold for the difference |
| pulse_valid | output | 1 | One-cycle strobe for a finished record |
| pulse_charge | output | 17 | Signed baseline-corrected charge |
| pulse_coarse | output | 16 | Sample index of the peak |
| pulse_fine | output | 4 | Sub-sample time step, 0..9 |
| pulse_ovf | output | 1 | Hit was cut at the length limit |

## Verification
Pulses with asymmetric, symmetric and flat-topped peaks are sent at every distance k, including the clamped codes 0 and 7. Together they separate errors in hit opening, in charge scaling and in the fine-step table. Pulses placed back to back, pulses on a baseline that has been raised, and pulses broken up by idle cycles check that the baseline window tracks the right samples and that idle cycles change nothing. A rising ramp exactly 32 samples long and one longer than that show the boundary of the length limit, and the samples after the cut show that the re-arm rule holds.

// File: rtl/qt_pkg.sv
package qt_pkg;
    localparam int SAMPLE_W   = 10;
    localparam int KMAX       = 4;
    localparam int PED_LEN    = 8;
    localparam int MAX_HIT    = 32;
    localparam int IDX_W      = 16;
    localparam int QB         = 3;
    localparam int FINE_STEPS = 10;

    localparam int PED_SH   = $clog2(PED_LEN);
    localparam int HIST_LEN = (PED_LEN > KMAX) ? PED_LEN : KMAX;
    localparam int K_W      = $clog2(KMAX) + 1;
    localparam int DOS_W    = SAMPLE_W + 1;
    localparam int LEN_W    = $clog2(MAX_HIT + 1);
    localparam int ACC_W    = SAMPLE_W + LEN_W;
    localparam int PSUM_W   = SAMPLE_W + PED_SH;
    localparam int CHG_W    = ACC_W + 1;
    localparam int FINE_W   = $clog2(FINE_STEPS);
    localparam int SH_W     = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    // one closed hit, handed from the tracker to the finishing stage
    typedef struct packed {
        logic              vld;
        logic              ovf;
        logic [ACC_W-1:0]  acc;
        logic [LEN_W-1:0]  len;
        logic [PSUM_W-1:0] ped;
        logic [IDX_W-1:0]  pidx;
        sample_t           peak;
        sample_t           left;
        sample_t           right;
    } hit_rec_t;
endpackage

// File: rtl/qt_hist.sv
module qt_hist
    import qt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic [K_W-1:0]          dos_k,
    output logic signed [DOS_W-1:0] dos,
    output logic [PSUM_W-1:0]       ped_sum,
    output logic [SAMPLE_W-1:0]     prev_sample
);
    typedef struct packed {
        sample_t [HIST_LEN-1:0] line;   // line[0] is the newest past sample
        logic [PSUM_W-1:0]      sum;    // sum of line[0..PED_LEN-1]
    } hist_st_t;

    hist_st_t s_d, s_q;
    logic [K_W-1:0] k_eff;
    sample_t        delayed;

    always_comb begin
        k_eff = dos_k;
        if (dos_k == '0) begin
            k_eff = K_W'(1);
        end else if (dos_k > K_W'(KMAX)) begin
            k_eff = K_W'(KMAX);
        end
        delayed = s_q.line[k_eff - K_W'(1)];
        dos     = $signed({1'b0, in_sample}) - $signed({1'b0, delayed});

        s_d = s_q;
        if (in_valid) begin
            s_d.line = {s_q.line[HIST_LEN-2:0], in_sample};
            s_d.sum  = s_q.sum + PSUM_W'(in_sample) - PSUM_W'(s_q.line[PED_LEN-1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ped_sum     = s_q.sum;
    assign prev_sample = s_q.line[0];

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ped_sum) && $stable(prev_sample)));
endmodule

// File: rtl/qt_track.sv
module qt_track
    import qt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic signed [DOS_W-1:0] dos,
    input  logic signed [DOS_W-1:0] dos_thr,
    input  logic [PSUM_W-1:0]       ped_sum,
    input  logic [SAMPLE_W-1:0]     prev_sample,
    output hit_rec_t                rec
);
    typedef struct packed {
        logic              in_hit;
        logic              prev_above;
        logic              rpend;      // peak is the newest hit sample
        logic [IDX_W-1:0]  idx;
        logic [ACC_W-1:0]  acc;
        logic [LEN_W-1:0]  len;
        logic [PSUM_W-1:0] ped;
        logic [IDX_W-1:0]  pidx;
        sample_t           peak;
        sample_t           left;
        sample_t           right;
        hit_rec_t          rec;
    } trk_st_t;

    trk_st_t s_d, s_q;
    logic    above;

    always_comb begin
        above = dos > dos_thr;
        s_d = s_q;
        s_d.rec.vld = 1'b0;
        if (in_valid) begin
            s_d.idx        = s_q.idx + IDX_W'(1);
            s_d.prev_above = above;
            if (s_q.in_hit) begin
                if (above && (s_q.len < LEN_W'(MAX_HIT))) begin
                    s_d.acc = s_q.acc + ACC_W'(in_sample);
                    s_d.len = s_q.len + LEN_W'(1);
                    if (in_sample > s_q.peak) begin
                        s_d.peak  = in_sample;
                        s_d.pidx  = s_q.idx;
                        s_d.left  = prev_sample;
                        s_d.rpend = 1'b1;
                    end else if (s_q.rpend) begin
                        s_d.right = in_sample;
                        s_d.rpend = 1'b0;
                    end
                end else begin
                    s_d.in_hit    = 1'b0;
                    s_d.rpend     = 1'b0;
                    s_d.rec.vld   = 1'b1;
                    s_d.rec.ovf   = above;
                    s_d.rec.acc   = s_q.acc;
                    s_d.rec.len   = s_q.len;
                    s_d.rec.ped   = s_q.ped;
                    s_d.rec.pidx  = s_q.pidx;
                    s_d.rec.peak  = s_q.peak;
                    s_d.rec.left  = s_q.left;
                    s_d.rec.right = s_q.rpend ? in_sample : s_q.right;
                end
            end else if (above && !s_q.prev_above) begin
                s_d.in_hit = 1'b1;
                s_d.acc    = ACC_W'(in_sample);
                s_d.len    = LEN_W'(1);
                s_d.ped    = ped_sum;
                s_d.pidx   = s_q.idx;
                s_d.peak   = in_sample;
                s_d.left   = prev_sample;
                s_d.right  = '0;
                s_d.rpend  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rec = s_q.rec;

    // R7
    hit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.in_hit |-> (s_q.len != '0 && s_q.len <= LEN_W'(MAX_HIT)));

    // R3
    close_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec.vld |=> !rec.vld);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.in_hit) |-> !$past(s_q.prev_above));
endmodule

// File: rtl/qt_finish.sv
module qt_finish
    import qt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  hit_rec_t                rec,
    output logic                    pulse_valid,
    output logic signed [CHG_W-1:0] pulse_charge,
    output logic [IDX_W-1:0]        pulse_coarse,
    output logic [FINE_W-1:0]       pulse_fine,
    output logic                    pulse_ovf
);
    localparam int LUT_N = 2 ** (2 * QB);
    localparam int NUM_W = ACC_W + PED_SH + 2;

    function automatic logic [LUT_N*FINE_W-1:0] build_lut();
        logic [LUT_N*FINE_W-1:0] t;
        int qa, qb, s, f;
        t = '0;
        for (int i = 0; i < LUT_N; i++) begin
            qa = i >> QB;
            qb = i % (2 ** QB);
            s  = qa + qb;
            if (s == 0) begin
                f = FINE_STEPS / 2;
            end else begin
                f = (2 * FINE_STEPS * qa + s) / (2 * s);
                if (f > FINE_STEPS - 1) f = FINE_STEPS - 1;
            end
            t[i*FINE_W +: FINE_W] = FINE_W'(f);
        end
        return t;
    endfunction

    localparam logic [LUT_N*FINE_W-1:0] FINE_LUT = build_lut();

    typedef struct packed {
        logic                    vld;
        logic                    ovf;
        logic signed [CHG_W-1:0] charge;
        logic [IDX_W-1:0]        coarse;
        logic [FINE_W-1:0]       fine;
    } out_st_t;

    out_st_t s_d, s_q;
    logic [NUM_W-1:0]        scaled_acc, ped_part;
    logic signed [NUM_W-1:0] num;
    sample_t                 drop_l, drop_r, mag;
    logic [SH_W-1:0]         shamt;
    logic [QB-1:0]           qa, qb;
    logic [2*QB-1:0]         addr;

    always_comb begin
        scaled_acc = NUM_W'(rec.acc) << PED_SH;
        ped_part   = NUM_W'(rec.len) * NUM_W'(rec.ped);
        num        = $signed(scaled_acc - ped_part);

        drop_l = (rec.peak > rec.left)  ? rec.peak - rec.left  : '0;
        drop_r = (rec.peak > rec.right) ? rec.peak - rec.right : '0;
        mag    = drop_l | drop_r;
        shamt  = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (mag[i]) begin
                if (i >= QB) begin
                    shamt = SH_W'(i - QB + 1);
                end else begin
                    shamt = '0;
                end
            end
        end
        qa   = QB'(drop_l >> shamt);
        qb   = QB'(drop_r >> shamt);
        addr = {qa, qb};

        s_d     = s_q;
        s_d.vld = rec.vld;
        if (rec.vld) begin
            s_d.ovf    = rec.ovf;
            s_d.charge = CHG_W'(num >>> PED_SH);
            s_d.coarse = rec.pidx;
            s_d.fine   = FINE_LUT[int'(addr)*FINE_W +: FINE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_valid  = s_q.vld;
    assign pulse_charge = s_q.charge;
    assign pulse_coarse = s_q.coarse;
    assign pulse_fine   = s_q.fine;
    assign pulse_ovf    = s_q.ovf;

    // R6
    fine_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid |-> (pulse_fine < FINE_W'(FINE_STEPS)));

    // R10
    rec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid |-> $past(rec.vld));

    // R10
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_valid |-> ($stable(pulse_charge) && $stable(pulse_coarse)
                          && $stable(pulse_fine) && $stable(pulse_ovf)));
endmodule

// File: rtl/qt_pulse_extract.sv
module qt_pulse_extract
    import qt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic [K_W-1:0]          dos_k,
    input  logic signed [DOS_W-1:0] dos_thr,
    output logic                    pulse_valid,
    output logic signed [CHG_W-1:0] pulse_charge,
    output logic [IDX_W-1:0]        pulse_coarse,
    output logic [FINE_W-1:0]       pulse_fine,
    output logic                    pulse_ovf
);
    logic signed [DOS_W-1:0] dos;
    logic [PSUM_W-1:0]       ped_sum;
    logic [SAMPLE_W-1:0]     prev_sample;
    hit_rec_t                rec;

    qt_hist u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .dos_k       (dos_k),
        .dos         (dos),
        .ped_sum     (ped_sum),
        .prev_sample (prev_sample)
    );

    qt_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .dos         (dos),
        .dos_thr     (dos_thr),
        .ped_sum     (ped_sum),
        .prev_sample (prev_sample),
        .rec         (rec)
    );

    qt_finish u_finish (
        .clk          (clk),
        .rst_n        (rst_n),
        .rec          (rec),
        .pulse_valid  (pulse_valid),
        .pulse_charge (pulse_charge),
        .pulse_coarse (pulse_coarse),
        .pulse_fine   (pulse_fine),
        .pulse_ovf    (pulse_ovf)
    );
endmodule

// File: tb/tb_qt_pulse_extract.sv
module tb_qt_pulse_extract;
    import qt_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic                    rst_n, in_valid;
    logic [SAMPLE_W-1:0]     in_sample;
    logic [K_W-1:0]          dos_k;
    logic signed [DOS_W-1:0] dos_thr;
    logic                    pulse_valid, pulse_ovf;
    logic signed [CHG_W-1:0] pulse_charge;
    logic [IDX_W-1:0]        pulse_coarse;
    logic [FINE_W-1:0]       pulse_fine;

    qt_pulse_extract dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .dos_k(dos_k), .dos_thr(dos_thr), .pulse_valid(pulse_valid),
        .pulse_charge(pulse_charge), .pulse_coarse(pulse_coarse),
        .pulse_fine(pulse_fine), .pulse_ovf(pulse_ovf)
    );

    typedef struct {
        int chg;
        int coarse;
        int fine;
        int ovf;
        int cyc;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   done = 1'b0, mon_on = 1'b0;

    // reference state built from the requirements
    int kc, tc;
    int mh[8];
    int m_in, m_prev, m_rpend, m_idx, m_acc, m_len, m_ped, m_pidx, m_peak, m_left, m_right;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_fine(int a, int b);
        int s, qa, qb, t, f;
        s = 0;
        while (((a >> s) >= 8) || ((b >> s) >= 8)) s++;
        qa = a >> s;
        qb = b >> s;
        t = qa + qb;
        if (t == 0) return 5;
        f = (20 * qa + t) / (2 * t);
        return (f > 9) ? 9 : f;
    endfunction

    task automatic model_step(int x, int c);
        int k, d, ab, a, b, r;
        exp_t e;
        k  = (kc < 1) ? 1 : ((kc > 4) ? 4 : kc);   // R2
        d  = x - mh[k-1];
        ab = (d > tc) ? 1 : 0;
        if (m_in != 0) begin
            if (ab != 0 && m_len < 32) begin
                m_acc += x;
                m_len++;
                if (x > m_peak) begin
                    m_peak = x; m_pidx = m_idx; m_left = mh[0]; m_rpend = 1;
                end else if (m_rpend != 0) begin
                    m_right = x; m_rpend = 0;
                end
            end else begin
                r = (m_rpend != 0) ? x : m_right;
                a = (m_peak > m_left) ? m_peak - m_left : 0;
                b = (m_peak > r) ? m_peak - r : 0;
                e.chg    = (8 * m_acc - m_len * m_ped) >>> 3;
                e.coarse = m_pidx;
                e.fine   = ref_fine(a, b);
                e.ovf    = ab;
                e.cyc    = c + 2;
                exp_q.push_back(e);
                m_in = 0;
                m_rpend = 0;
            end
        end else if (ab != 0 && m_prev == 0) begin
            m_in = 1; m_acc = x; m_len = 1; m_pidx = m_idx; m_peak = x;
            m_left = mh[0]; m_right = 0; m_rpend = 1;
            m_ped = 0;
            for (int i = 0; i < 8; i++) m_ped += mh[i];
        end
        for (int i = 7; i > 0; i--) mh[i] = mh[i-1];
        mh[0]  = x;
        m_idx  = (m_idx + 1) % 65536;
        m_prev = ab;
    endtask

    task automatic feed(int x);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SAMPLE_W'(x);
        model_step(x, cyc);
    endtask

    task automatic gap(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = '1;     // R9: ignored
        end
    endtask

    task automatic cfg(int k, int thr);
        kc = k; tc = thr;
        dos_k   = K_W'(k);
        dos_thr = DOS_W'(thr);
    endtask

    task automatic pulse8(int base, int v0, int v1, int v2, int v3,
                          int v4, int v5, int v6, int v7);
        feed(base + v0); feed(base + v1); feed(base + v2); feed(base + v3);
        feed(base + v4); feed(base + v5); feed(base + v6); feed(base + v7);
        repeat (8) feed(base);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && pulse_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected pulse at coarse", int'(pulse_coarse), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cyc == e.cyc, "R10", "pulse cycle", cyc, e.cyc);
                chk(int'(pulse_charge) == e.chg, "R4", "charge", int'(pulse_charge), e.chg);
                chk(int'(pulse_coarse) == e.coarse, "R5", "coarse", int'(pulse_coarse), e.coarse);
                chk(int'(pulse_fine) == e.fine, "R6", "fine", int'(pulse_fine), e.fine);
                chk(int'(pulse_ovf) == e.ovf, "R7", "overflow", int'(pulse_ovf), e.ovf);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R10", "watchdog expired", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
        cfg(1, 30);
        for (int i = 0; i < 8; i++) mh[i] = 0;
        m_in = 0; m_prev = 0; m_rpend = 0; m_idx = 0; m_acc = 0; m_len = 0;
        m_ped = 0; m_pidx = 0; m_peak = 0; m_left = 0; m_right = 0;
        repeat (3) @(negedge clk);
        // R1: held in reset
        chk(pulse_valid == 1'b0 && pulse_charge == '0 && pulse_coarse == '0
            && pulse_fine == '0 && pulse_ovf == 1'b0, "R1", "outputs in reset",
            int'(pulse_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pulse_valid == 1'b0 && pulse_charge == '0 && pulse_coarse == '0
            && pulse_fine == '0 && pulse_ovf == 1'b0, "R1", "outputs after reset",
            int'(pulse_charge), 0);
        mon_on = 1'b1;

        repeat (12) feed(0);
        for (int i = 1; i <= 20; i++) feed(5 * i);   // baseline to 100
        repeat (10) feed(100);

        // R3 R4 R6: various shapes and distances (R2)
        cfg(1, 30); pulse8(100, 40, 200, 300, 220, 120, 50, 10, 0);
        cfg(2, 50); pulse8(100, 30, 120, 400, 600, 350, 150, 60, 0);
        cfg(3, 40); pulse8(100, 20, 90, 250, 500, 480, 300, 100, 20);
        cfg(4, 60); pulse8(100, 10, 60, 180, 700, 690, 400, 120, 30);
        cfg(0, 30); pulse8(100, 200, 500, 500, 200, 0, 0, 0, 0);       // R2 code 0, R6 clamp to 9
        cfg(7, 30); pulse8(100, 50, 300, 800, 300, 50, 0, 0, 0);       // R2 code 7, symmetric peak
        cfg(1, 30); pulse8(100, 300, 0, 300, 0, 300, 0, 0, 0);         // R3 back to back

        // R4: raised baseline changes the pedestal
        for (int i = 1; i <= 40; i++) feed(100 + 5 * i);
        repeat (8) feed(300);
        pulse8(300, 60, 350, 700, 500, 200, 80, 0, 0);

        // R9: idle cycles inside a pulse
        feed(400); gap(3); feed(700); gap(2); feed(650); gap(4); feed(450);
        feed(320); gap(1); feed(300);
        repeat (8) feed(300);

        // back to base 100
        for (int i = 1; i <= 40; i++) feed(300 - 5 * i);
        repeat (8) feed(100);

        // R7 boundary: exactly 32 samples, no overflow
        cfg(1, 10);
        for (int i = 1; i <= 32; i++) feed(100 + 20 * i);
        feed(100);
        repeat (8) feed(100);

        // R7 R8: longer than 32, cut and not reopened while still rising
        for (int i = 1; i <= 40; i++) feed(100 + 20 * i);
        for (int i = 1; i <= 10; i++) feed(900 - 80 * i);
        repeat (8) feed(100);

        // R8: normal pulse after rearm
        cfg(2, 40); pulse8(100, 30, 250, 420, 380, 150, 40, 0, 0);

        repeat (10) feed(100);
        gap(6);
        chk(exp_q.size() == 0, "R3", "records still missing", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule